// File: doc/BRIEF.md
# APB Programmable Down-Counter Timer

This block is a single down-counting timer that sits on an APB bus as a slave. Software writes a start value, picks a clock division ratio and a mode, and enables the counter. The counter then decrements on a prescaled enable derived from the bus clock. When it steps from one to zero it sets a sticky status flag. If the interrupt is enabled, the flag drives the interrupt pin.

There are two modes. Continuous mode restarts from the stored start value after zero, which gives a fixed period. One-shot mode parks at zero until software restarts it. The counter width (16 or 32 bits) and the interrupt pin polarity are fixed by parameters at elaboration. The block uses no clock other than the bus clock.

The register words sit at byte offsets 0x00 (start value, read/write), 0x04 (present count, read only), 0x08 (control), 0x0C (divider code) and 0x10 (status read / clear write). An access hits only when the address bits above bit 4 and the two low bits are zero.

Top module: `apb_dtimer`

## Requirements
- R1: Every transfer completes with no wait state and no error (`pready` high, `pslverr` low). Read data is valid during the access phase. Unused bits and unmapped word offsets read as zero.
- R2: A write to offset 0x00 stores the value truncated to the counter width. The counter takes that value on the same clock edge, and the divider restarts from zero. A write to offset 0x00 takes priority over a count step in the same cycle.
- R3: While control bit 0 (enable) is clear, the count does not change except through a write to offset 0x00.
- R4: Bits 3:0 at offset 0x0C hold a code N. While enabled, the counter steps once every 2^N clock cycles, with the first step 2^N cycles after the enabling edge. Codes above 10 act as 10, so the largest division is 1024. The code reads back as written.
- R5: In continuous mode (control bit 2 clear, the reset value), a step taken at zero reloads the stored start value.
- R6: In one-shot mode (control bit 2 set), a counter at zero stays at zero.
- R7: A one-shot counter parked at zero resumes counting when bit 2 is cleared, or when a new start value is written.
- R8: Status bit 0 at offset 0x10 is set by a step from one to zero. It stays set until a write with bit 0 set to offset 0x10. A set and a clear in the same cycle leave it set.
- R9: The interrupt pin is active exactly while the status bit and control bit 1 (interrupt enable) are both set. Parameter `IRQ_ACT_HIGH`=1 makes active mean high; 0 makes active mean low.
- R10: Parameter `WIDE32`=1 gives a 32-bit counter and 0 gives a 16-bit counter. For 16 bits, the start value and count read back zero-extended.
- R11: After reset, the start value, count, control, divider code and status are all zero, and the interrupt pin is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the timer's only clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done, always high |
| pslverr | output | 1 | Error response, always low |
| tmr_irq | output | 1 | Interrupt, polarity set by IRQ_ACT_HIGH |

## Verification
A count register that is off by one state shows up at the count read-back on the next read. It appears as the wrong value on the following divided step and again at every reload, because continuous mode repeats the error every period. A divider that fails to restart on a start-value write, or that ignores the code clamp, moves every step by whole clock cycles. The tests catch this by reading the count within a few cycles of a known edge. A wrong status flag shows on the interrupt pin in the cycle after the step to zero, and it either persists or vanishes across a clear write that meets a new zero step.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int DATA_W     = 32;
  localparam int WORD_IDX_W = 3;
  localparam int PSC_CODE_W = 4;
  localparam int PSC_MAX    = 10;
  localparam int PSC_CNT_W  = PSC_MAX;

  localparam logic [WORD_IDX_W-1:0] WIDX_START = 3'd0;
  localparam logic [WORD_IDX_W-1:0] WIDX_COUNT = 3'd1;
  localparam logic [WORD_IDX_W-1:0] WIDX_CTRL  = 3'd2;
  localparam logic [WORD_IDX_W-1:0] WIDX_PSC   = 3'd3;
  localparam logic [WORD_IDX_W-1:0] WIDX_STAT  = 3'd4;

  typedef struct packed {
    logic oneshot;
    logic irq_en;
    logic run;
  } ctrl_t;

  function automatic int psc_clamp(input logic [PSC_CODE_W-1:0] code);
    return (int'(code) > PSC_MAX) ? PSC_MAX : int'(code);
  endfunction

  function automatic logic [PSC_CNT_W-1:0] psc_mask(input logic [PSC_CODE_W-1:0] code);
    int sh;
    sh = psc_clamp(code);
    return PSC_CNT_W'((1 << sh) - 1);
  endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
  import dtmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  restart,
  input  logic [PSC_CODE_W-1:0] code,
  output logic                  tick
);

  logic [PSC_CNT_W-1:0] div_q;
  logic [PSC_CNT_W-1:0] mask;

  assign mask = psc_mask(code);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart || !run) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/dtmr_count.sv
module dtmr_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load_wr,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          oneshot,
  output logic [CW-1:0] cnt,
  output logic          zero_hit
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_zero;

  assign at_zero  = (cnt_q == '0);
  assign zero_hit = tick && !load_wr && (cnt_q == ONE);
  assign cnt      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (!at_zero) begin
        cnt_d = cnt_q - ONE;
      end else if (!oneshot) begin
        cnt_d = reload_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int CW     = 32,
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic [CW-1:0]         cnt,
  input  logic                  zero_hit,
  output logic [DATA_W-1:0]     prdata,
  output logic                  load_wr,
  output logic [CW-1:0]         load_q,
  output ctrl_t                 ctrl_q,
  output logic [PSC_CODE_W-1:0] psc_q,
  output logic                  status_q,
  output logic                  clr_wr
);

  logic                  hit;
  logic [WORD_IDX_W-1:0] widx;
  logic                  wr_acc;
  logic                  ctrl_wr;
  logic                  psc_wr;
  logic                  stat_wr;

  assign hit    = (paddr[ADDR_W-1:5] == '0) && (paddr[1:0] == 2'b00);
  assign widx   = paddr[4:2];
  assign wr_acc = psel && penable && pwrite && hit;

  assign load_wr = wr_acc && (widx == WIDX_START);
  assign ctrl_wr = wr_acc && (widx == WIDX_CTRL);
  assign psc_wr  = wr_acc && (widx == WIDX_PSC);
  assign stat_wr = wr_acc && (widx == WIDX_STAT);
  assign clr_wr  = stat_wr && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
      psc_q  <= '0;
    end else begin
      if (load_wr) load_q <= pwdata[CW-1:0];
      if (ctrl_wr) ctrl_q <= ctrl_t'(pwdata[2:0]);
      if (psc_wr)  psc_q  <= pwdata[PSC_CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (zero_hit) begin
      status_q <= 1'b1;
    end else if (clr_wr) begin
      status_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && hit) begin
      case (widx)
        WIDX_START: prdata = DATA_W'(load_q);
        WIDX_COUNT: prdata = DATA_W'(cnt);
        WIDX_CTRL:  prdata = DATA_W'(ctrl_q);
        WIDX_PSC:   prdata = DATA_W'(psc_q);
        WIDX_STAT:  prdata = DATA_W'(status_q);
        default:    prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
  import dtmr_pkg::*;
#(
  parameter int WIDE32       = 1,
  parameter int IRQ_ACT_HIGH = 1,
  parameter int ADDR_W       = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              tmr_irq
);

  localparam int CNT_W = (WIDE32 != 0) ? 32 : 16;

  logic                  load_wr;
  logic [CNT_W-1:0]      load_q;
  logic [CNT_W-1:0]      cnt_q;
  ctrl_t                 ctrl_q;
  logic [PSC_CODE_W-1:0] psc_q;
  logic                  status_q;
  logic                  clr_wr;
  logic                  tick;
  logic                  zero_hit;
  logic                  run_en;
  logic                  oneshot_mode;
  logic                  irq_act;

  assign run_en       = ctrl_q.run;
  assign oneshot_mode = ctrl_q.oneshot;
  assign irq_act      = status_q && ctrl_q.irq_en;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  dtmr_regs #(.CW(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (pclk),
    .rst_n    (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .cnt      (cnt_q),
    .zero_hit (zero_hit),
    .prdata   (prdata),
    .load_wr  (load_wr),
    .load_q   (load_q),
    .ctrl_q   (ctrl_q),
    .psc_q    (psc_q),
    .status_q (status_q),
    .clr_wr   (clr_wr)
  );

  dtmr_prescale u_psc (
    .clk     (pclk),
    .rst_n   (presetn),
    .run     (run_en),
    .restart (load_wr),
    .code    (psc_q),
    .tick    (tick)
  );

  dtmr_count #(.CW(CNT_W)) u_cnt (
    .clk        (pclk),
    .rst_n      (presetn),
    .tick       (tick),
    .load_wr    (load_wr),
    .load_val   (pwdata[CNT_W-1:0]),
    .reload_val (load_q),
    .oneshot    (oneshot_mode),
    .cnt        (cnt_q),
    .zero_hit   (zero_hit)
  );

  generate
    if (IRQ_ACT_HIGH != 0) begin : g_irq_hi
      assign tmr_irq = irq_act;
    end else begin : g_irq_lo
      assign tmr_irq = !irq_act;
    end
  endgenerate

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          load_wr,
  input logic [CW-1:0] load_val,
  input logic [CW-1:0] reload_val,
  input logic [CW-1:0] cnt,
  input logic          run_en,
  input logic          oneshot,
  input logic          status,
  input logic          clr_wr,
  input logic          zero_hit
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt == $past(load_val))); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr) |=> $stable(cnt)); // R3

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run_en); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && (cnt != '0)) |=> (cnt == ($past(cnt) - ONE))); // R4

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && (cnt == '0) && !oneshot) |=> (cnt == $past(reload_val))); // R5

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && oneshot && (cnt == '0)) |=> (cnt == '0)); // R6

  AST_ZERO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> status); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_wr) |=> status); // R8

endmodule

bind apb_dtimer dtmr_chk #(.CW(CNT_W)) u_chk (
  .clk        (pclk),
  .rst_n      (presetn),
  .tick       (tick),
  .load_wr    (load_wr),
  .load_val   (pwdata[CNT_W-1:0]),
  .reload_val (load_q),
  .cnt        (cnt_q),
  .run_en     (run_en),
  .oneshot    (oneshot_mode),
  .status     (status_q),
  .clr_wr     (clr_wr),
  .zero_hit   (zero_hit)
);

// File: tb/tb_apb_dtimer.sv
`timescale 1ns/1ps
module tb_apb_dtimer;

  localparam int AW = 12;
  localparam logic [AW-1:0] A_START = 12'h000;
  localparam logic [AW-1:0] A_COUNT = 12'h004;
  localparam logic [AW-1:0] A_CTRL  = 12'h008;
  localparam logic [AW-1:0] A_PSC   = 12'h00C;
  localparam logic [AW-1:0] A_STAT  = 12'h010;

  typedef struct packed {
    logic [31:0] ld;
    logic [3:0]  code;
    logic [15:0] k;
    logic        os;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'd10,  4'd0,  16'd3,    1'b0},
    '{32'd3,   4'd0,  16'd8,    1'b0},
    '{32'd100, 4'd2,  16'd18,   1'b0},
    '{32'd5,   4'd3,  16'd30,   1'b1},
    '{32'd2,   4'd0,  16'd10,   1'b1},
    '{32'd20,  4'd12, 16'd2046, 1'b0},
    '{32'd20,  4'd10, 16'd1022, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel_bus = 1'b0;
  logic penable = 1'b0;
  logic pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic tgt = 1'b0;
  logic [31:0] prdata32, prdata16;
  logic pready32, pslverr32, irq32;
  logic pready16, pslverr16, irq16;
  logic psel32, psel16;
  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  assign psel32 = psel_bus & ~tgt;
  assign psel16 = psel_bus & tgt;

  apb_dtimer #(.WIDE32(1), .IRQ_ACT_HIGH(1), .ADDR_W(AW)) dut (
    .pclk(clk), .presetn(rst_n), .psel(psel32), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata32),
    .pready(pready32), .pslverr(pslverr32), .tmr_irq(irq32));

  apb_dtimer #(.WIDE32(0), .IRQ_ACT_HIGH(0), .ADDR_W(AW)) dut16 (
    .pclk(clk), .presetn(rst_n), .psel(psel16), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata16),
    .pready(pready16), .pslverr(pslverr16), .tmr_irq(irq16));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    psel_bus = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel_bus = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    psel_bus = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    #1 d = tgt ? prdata16 : prdata32;
    @(posedge clk); @(negedge clk);
    psel_bus = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] model(input vec_t v);
    int e, c, t;
    logic [31:0] x;
    e = int'(v.k) + 2;
    c = (int'(v.code) > 10) ? 10 : int'(v.code);
    t = e >> c;
    x = v.ld;
    for (int i = 0; i < t; i++) begin
      if (x == 0) begin
        if (!v.os) x = v.ld;
      end else begin
        x = x - 1;
      end
    end
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state and R1 bus response
    rd(A_START, d); chk("R11 start", d, 0);
    rd(A_COUNT, d); chk("R11 count", d, 0);
    rd(A_CTRL, d);  chk("R11 ctrl", d, 0);
    rd(A_PSC, d);   chk("R11 psc", d, 0);
    rd(A_STAT, d);  chk("R11 status", d, 0);
    chk("R11 irq32 inactive", {31'd0, irq32}, 0);
    chk("R1 pready", {31'd0, pready32}, 1);
    chk("R1 pslverr", {31'd0, pslverr32}, 0);
    rd(12'h014, d); chk("R1 unmapped", d, 0);

    // Table walk: R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 0);
      wr(A_PSC, {28'd0, VECS[i].code});
      wr(A_START, VECS[i].ld);
      wr(A_CTRL, {29'd0, VECS[i].os, 1'b0, 1'b1});
      repeat (int'(VECS[i].k)) @(negedge clk);
      wr(A_CTRL, 0);
      rd(A_COUNT, d);
      chk($sformatf("R4/R5/R6 vector %0d count", i), d, model(VECS[i]));
    end

    // R4 code readback and R1 reserved bits
    wr(A_PSC, 32'hFFFF_FFF5); rd(A_PSC, d); chk("R4 code readback", d, 5);
    wr(A_CTRL, 32'hFFFF_FFF8); rd(A_CTRL, d); chk("R1 reserved ctrl", d, 0);

    // R3 disabled holds
    wr(A_START, 9);
    repeat (20) @(negedge clk);
    rd(A_COUNT, d); chk("R3 idle hold", d, 9);

    // R2 start write restarts divider
    wr(A_PSC, 2); wr(A_START, 50); wr(A_CTRL, 1);
    repeat (2) @(negedge clk);
    wr(A_START, 40);
    rd(A_COUNT, d); chk("R2 load immediate", d, 40);
    rd(A_COUNT, d); chk("R2 divider restart", d, 40);
    rd(A_COUNT, d); chk("R2 first step after 4", d, 39);
    wr(A_CTRL, 0);

    // R6 park, R9 pin, R7 restart by mode clear, R8 set wins
    wr(A_PSC, 0); wr(A_STAT, 1); wr(A_START, 3); wr(A_CTRL, 7);
    repeat (10) @(negedge clk);
    rd(A_COUNT, d); chk("R6 parked", d, 0);
    rd(A_STAT, d); chk("R8 status set", d, 1);
    chk("R9 irq32 active", {31'd0, irq32}, 1);
    wr(A_CTRL, 3);
    rd(A_COUNT, d); chk("R7 mode clear restart", d, 3);
    wr(A_STAT, 1);
    rd(A_STAT, d); chk("R8 set beats clear", d, 1);
    wr(A_CTRL, 0); wr(A_STAT, 1);
    rd(A_STAT, d); chk("R8 cleared", d, 0);
    chk("R9 irq32 released", {31'd0, irq32}, 0);

    // R7 restart by start write
    wr(A_START, 2); wr(A_CTRL, 5);
    repeat (6) @(negedge clk);
    rd(A_COUNT, d); chk("R6 parked again", d, 0);
    wr(A_START, 4);
    rd(A_COUNT, d); chk("R7 start-write restart", d, 3);
    wr(A_CTRL, 0);

    // R9 interrupt enable gating
    wr(A_STAT, 1); wr(A_START, 1); wr(A_CTRL, 1);
    repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R8 status without enable", d, 1);
    chk("R9 gated pin", {31'd0, irq32}, 0);
    wr(A_CTRL, 0); wr(A_STAT, 1);

    // R10 / R9 on 16-bit active-low instance
    tgt = 1'b1;
    chk("R9 irq16 idle high", {31'd0, irq16}, 1);
    wr(A_START, 32'h0001_0002);
    rd(A_START, d); chk("R10 truncated start", d, 32'h2);
    wr(A_CTRL, 7);
    repeat (6) @(negedge clk);
    rd(A_COUNT, d); chk("R10 16-bit count", d, 0);
    chk("R9 irq16 active low", {31'd0, irq16}, 0);
    wr(A_START, 32'hFFFF_FFFF);
    wr(A_CTRL, 0);
    rd(A_START, d); chk("R10 max start", d, 32'h0000_FFFF);
    tgt = 1'b0;

    report();
    $finish;
  end

endmodule